// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns one loop trip count into a schedule of vector chunks for a vector unit whose registers hold at most `MAX_VL` elements. A one-cycle start pulse loads the count. The block then offers the chunks one at a time. Each chunk carries its first element index and its vector length. A valid/ready handshake hands each chunk over, and a one-cycle done pulse follows once every iteration is covered.

The partial chunk comes first. Its length is the count modulo `MAX_VL`. When the count divides evenly, the first chunk is a full one instead of an empty one. Every later chunk is exactly `MAX_VL` long. After each accepted chunk the start index grows by the length just issued, and the remaining count shrinks by the same amount. A zero count issues no chunk at all and only signals done. The vector datapath and address generation sit outside this block.

Top module: `vlseq_strip_mine`

## Requirements
- R1: After reset, `chunk_valid` and `done` are both low.
- R2: The first chunk of a nonzero count appears on the cycle after the start pulse. It has `chunk_idx` = 0 and `chunk_vl` = count mod `MAX_VL` whenever that remainder is nonzero.
- R3: When the count is a nonzero multiple of `MAX_VL`, the first chunk has `chunk_vl` = `MAX_VL`, never 0.
- R4: Every chunk after the first has `chunk_vl` = `MAX_VL`.
- R5: Each chunk's `chunk_idx` equals the previous chunk's `chunk_idx` plus the previous chunk's `chunk_vl`. The lengths of all chunks add up to the count.
- R6: While `chunk_valid` is high and `chunk_ready` is low, `chunk_valid`, `chunk_idx` and `chunk_vl` hold their values into the next cycle.
- R7: A start with count 0 issues no chunk, and `done` is high for exactly the one cycle after the start pulse.
- R8: `done` is high for exactly one cycle, starting the cycle after the last chunk is accepted. It is low while any chunk is still outstanding, and it is never high together with `chunk_valid`.
- R9: A start pulse that arrives while a schedule is in progress is ignored. The chunks already being issued go on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to schedule `trip_count` |
| trip_count | input | CNT_W (24) | Total loop iterations to cover |
| chunk_valid | output | 1 | A chunk is being offered |
| chunk_ready | input | 1 | The consumer takes the offered chunk |
| chunk_idx | output | CNT_W (24) | First element index of the chunk |
| chunk_vl | output | $clog2(MAX_VL+1) (7) | Element count of the chunk |
| done | output | 1 | One-cycle pulse once the whole count is covered |

## Verification
The bench builds the block with `CNT_W` = 8 and `MAX_VL` = 4. This lets it sweep every trip count from 0 to 255, which covers every remainder class, every exact multiple and the largest count the index can reach. The consumer's ready follows a pseudo-random pattern, so chunks are held across stalls and also accepted back to back. On some counts a second start pulse is injected while the first chunk stalls, to show that it is ignored.

// File: rtl/vlseq_pkg.sv
package vlseq_pkg;

    // Default configuration of the sequencer.
    localparam int unsigned DEF_CNT_W  = 24;
    localparam int unsigned DEF_MAX_VL = 64;

    // Sequencer phase.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ISSUE = 1'b1
    } phase_e;

    // True when v is a nonzero power of two.
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/vlseq_first_len.sv
// Length of the leading partial chunk: count mod MAX_VL, promoted to MAX_VL
// when the remainder is zero. A zero count yields zero.
module vlseq_first_len #(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned MAX_VL = 64,
    localparam int unsigned VL_W  = $clog2(MAX_VL + 1),
    localparam int unsigned LOG_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic [CNT_W-1:0] count,
    output logic [VL_W-1:0]  first_vl
);
    import vlseq_pkg::*;

    logic [VL_W-1:0] rem_w;

    generate
        if (is_pow2(MAX_VL) && MAX_VL > 1) begin : g_pow2
            // Remainder is just the low bits of the count.
            assign rem_w = VL_W'(count[LOG_W-1:0]);
        end else begin : g_div
            logic [CNT_W-1:0] rem_full;
            assign rem_full = count % CNT_W'(MAX_VL);
            assign rem_w    = VL_W'(rem_full);
        end
    endgenerate

    always_comb begin
        if (count == '0) begin
            first_vl = '0;
        end else if (rem_w == '0) begin
            first_vl = VL_W'(MAX_VL);
        end else begin
            first_vl = rem_w;
        end
    end

    // Immediate check: the length never exceeds the hardware limit.
    always_comb begin
        AST_FIRST_IN_RANGE: assert (first_vl <= VL_W'(MAX_VL)); // R2
    end

endmodule

// File: rtl/vlseq_advance.sv
// Step logic: moves the index and the remaining count past the current chunk
// and flags the final chunk.
module vlseq_advance #(
    parameter int unsigned CNT_W  = 24,
    parameter int unsigned MAX_VL = 64,
    localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic [CNT_W-1:0] idx_cur,
    input  logic [CNT_W-1:0] remain_cur,
    input  logic [VL_W-1:0]  vl_cur,
    output logic [CNT_W-1:0] idx_next,
    output logic [CNT_W-1:0] remain_next,
    output logic             is_last
);
    logic [CNT_W-1:0] vl_ext;

    always_comb begin
        vl_ext      = CNT_W'(vl_cur);
        idx_next    = idx_cur + vl_ext;
        remain_next = remain_cur - vl_ext;
        is_last     = (remain_cur <= vl_ext);
    end

endmodule

// File: rtl/vlseq_strip_mine.sv
// Top of the strip-mining sequencer: one struct of state, one next-state
// process, one register process.
module vlseq_strip_mine #(
    parameter int unsigned CNT_W  = vlseq_pkg::DEF_CNT_W,
    parameter int unsigned MAX_VL = vlseq_pkg::DEF_MAX_VL,
    localparam int unsigned VL_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] trip_count,
    output logic             chunk_valid,
    input  logic             chunk_ready,
    output logic [CNT_W-1:0] chunk_idx,
    output logic [VL_W-1:0]  chunk_vl,
    output logic             done
);
    import vlseq_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] remain;
        logic [VL_W-1:0]  vl;
        logic             done;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic [VL_W-1:0]  first_vl;
    logic [CNT_W-1:0] idx_step;
    logic [CNT_W-1:0] remain_step;
    logic             last_chunk;

    vlseq_first_len #(
        .CNT_W  (CNT_W),
        .MAX_VL (MAX_VL)
    ) u_first_len (
        .count    (trip_count),
        .first_vl (first_vl)
    );

    vlseq_advance #(
        .CNT_W  (CNT_W),
        .MAX_VL (MAX_VL)
    ) u_advance (
        .idx_cur     (st_q.idx),
        .remain_cur  (st_q.remain),
        .vl_cur      (st_q.vl),
        .idx_next    (idx_step),
        .remain_next (remain_step),
        .is_last     (last_chunk)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (trip_count == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase  = PH_ISSUE;
                        st_d.idx    = '0;
                        st_d.remain = trip_count;
                        st_d.vl     = first_vl;
                    end
                end
            end
            PH_ISSUE: begin
                if (chunk_ready) begin
                    if (last_chunk) begin
                        st_d.phase  = PH_IDLE;
                        st_d.done   = 1'b1;
                        st_d.remain = '0;
                    end else begin
                        st_d.idx    = idx_step;
                        st_d.remain = remain_step;
                        st_d.vl     = VL_W'(MAX_VL);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chunk_valid = (st_q.phase == PH_ISSUE);
    assign chunk_idx   = st_q.idx;
    assign chunk_vl    = st_q.vl;
    assign done        = st_q.done;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_idx) && $stable(chunk_vl)); // R6
    AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && chunk_ready |=> !chunk_valid || chunk_vl == VL_W'(MAX_VL)); // R4
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && chunk_ready |=> !chunk_valid ||
        chunk_idx == $past(chunk_idx) + CNT_W'($past(chunk_vl))); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && chunk_valid)); // R8
    AST_VL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> chunk_vl != '0 && chunk_vl <= VL_W'(MAX_VL)); // R3

endmodule

// File: tb/tb_vlseq_strip_mine.sv
`timescale 1ns/1ps
module tb_vlseq_strip_mine;
    localparam int CW = 8;
    localparam int MV = 4;
    localparam int VW = $clog2(MV + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] trip_count = '0;
    logic          chunk_valid;
    logic          chunk_ready = 1'b0;
    logic [CW-1:0] chunk_idx;
    logic [VW-1:0] chunk_vl;
    logic          done;

    int n_vec  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    vlseq_strip_mine #(.CNT_W(CW), .MAX_VL(MV)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .trip_count  (trip_count),
        .chunk_valid (chunk_valid),
        .chunk_ready (chunk_ready),
        .chunk_idx   (chunk_idx),
        .chunk_vl    (chunk_vl),
        .done        (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit next_ready();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0] | lfsr[3];
    endfunction

    task automatic run_count(input int c, input bit inject);
        int exp_idx;
        int exp_vl;
        int remain;
        bit first;
        bit waited;
        bit injected;
        bit rdy;
        int last_idx;
        int last_vl;
        string lbl;
        @(negedge clk);
        start = 1'b1; trip_count = CW'(c); chunk_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (c == 0) begin
            check(!chunk_valid, "R7", int'(chunk_valid), 0);
            check(done == 1'b1, "R7", int'(done), 1);
            @(negedge clk);
            check(done == 1'b0, "R7", int'(done), 0);
            return;
        end
        exp_idx = 0;
        exp_vl  = (c % MV == 0) ? MV : (c % MV);
        remain  = c;
        first   = 1'b1;
        waited  = 1'b0;
        injected = 1'b0;
        last_idx = 0;
        last_vl  = 0;
        while (remain > 0) begin
            check(chunk_valid == 1'b1, first ? "R2" : "R4", int'(chunk_valid), 1);
            check(done == 1'b0, "R8", int'(done), 0);
            if (waited) begin
                check(int'(chunk_idx) == last_idx && int'(chunk_vl) == last_vl, "R6",
                      int'(chunk_idx), last_idx);
            end
            lbl = injected ? "R9" : "R5";
            check(int'(chunk_idx) == exp_idx, lbl, int'(chunk_idx), exp_idx);
            if (injected) lbl = "R9";
            else if (!first) lbl = "R4";
            else if (c % MV == 0) lbl = "R3";
            else lbl = "R2";
            check(int'(chunk_vl) == exp_vl, lbl, int'(chunk_vl), exp_vl);
            last_idx = int'(chunk_idx);
            last_vl  = int'(chunk_vl);
            injected = 1'b0;
            rdy = next_ready();
            if (inject && first && !rdy) begin
                start = 1'b1;
                trip_count = CW'(1);
                injected = 1'b1;
                inject = 1'b0;
            end
            chunk_ready = rdy;
            if (rdy) begin
                remain  -= exp_vl;
                exp_idx += exp_vl;
                exp_vl   = MV;
                first    = 1'b0;
                waited   = 1'b0;
            end else begin
                waited = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chunk_ready = 1'b0;
        // R5: all chunk lengths together equal the count
        check(exp_idx == c, "R5", exp_idx, c);
        check(done == 1'b1, "R8", int'(done), 1);
        check(chunk_valid == 1'b0, "R8", int'(chunk_valid), 0);
        @(negedge clk);
        check(done == 1'b0, "R8", int'(done), 0);
        check(chunk_valid == 1'b0, "R9", int'(chunk_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(chunk_valid == 1'b0, "R1", int'(chunk_valid), 0);
        check(done == 1'b0, "R1", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(chunk_valid == 1'b0, "R1", int'(chunk_valid), 0);
        check(done == 1'b0, "R1", int'(done), 0);
        for (int c = 0; c < (1 << CW); c++) begin
            run_count(c, (c % 3) == 0);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule